// File: doc/BRIEF.md
# Ring Accelerator Address Proxy

This block keeps the pointer state of several circular work rings that live in memory. Producers and consumers never see a ring's base address or its offsets. A master names a ring on the read port or the write port, and the block issues the memory access itself. A read goes to the ring's current head slot. A write goes to the ring's current tail slot. The block then advances the pointer it used and updates the ring's occupancy. Because the state sits in one place, many masters can share a ring, and each access still claims the next slot exactly once.

A register port sets each ring's base address, its size (a power of two) and its mode. The same port carries a doorbell, which reports a batch of elements that a producer wrote on its own, and a per-ring clear command. The occupancy counter is a modular counter, so a sequence of doorbells can wrap it back to zero on purpose. Status outputs show each ring's empty flag, full flag and occupancy.

Top module: `ring_proxy`

## Requirements
- R1: A read request on a ring that is not empty produces, one cycle later, `mem_rd_valid_o` with address base + head × ELEM_BYTES. The head then advances by one, modulo the ring size.
- R2: A write request on a ring that is not full produces, one cycle later, `mem_wr_valid_o` with address base + tail × ELEM_BYTES. The tail then advances by one, modulo the ring size.
- R3: Successive accesses to one ring take consecutive distinct slots. An offset wraps to 0 when it reaches the ring size, which is 2^size_log2.
- R4: The block refuses a read on an empty ring and a write on a full ring. A refused access pulses `rd_err_o` or `wr_err_o` one cycle later, raises no memory valid, and leaves the pointers unchanged.
- R5: A read and a write to the same ring in the same cycle are both served, and the occupancy changes by the net amount.
- R6: In ring mode, a doorbell (op 2, count in `reg_data_i`) adds the count to the occupancy and advances the tail by the count, modulo the ring size. In the same cycle as a window access, the doorbell adds on top of the access.
- R7: A doorbell count above DB_MAX (100 by default) is treated as DB_MAX.
- R8: The occupancy is an OCC_W-bit modular counter. Doorbells totalling 2^OCC_W minus the occupancy return it to exactly 0.
- R9: A clear command (op 3) sets the head, the tail and the occupancy of that ring to 0.
- R10: A configuration write (op 1) sets size_log2 from `reg_data_i[2:0]`, limited to MAX_LOG, and the mode from `reg_data_i[7]` (0 = ring, 1 = queue). In queue mode a doorbell has no effect. Changing the mode leaves the pointers and the occupancy as they are.
- R11: `empty_o[r]` is 1 exactly when the occupancy is 0. `full_o[r]` is 1 when the occupancy is at least the ring size. `occ_o[r*OCC_W +: OCC_W]` shows the occupancy.
- R12: After reset, every ring has base 0 (op 0 writes the base), size_log2 = MAX_LOG, ring mode, and zero pointers and occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read window request |
| rd_ring_i | input | RING_W | Ring named by the read request |
| wr_valid_i | input | 1 | Write window request |
| wr_ring_i | input | RING_W | Ring named by the write request |
| reg_valid_i | input | 1 | Register command strobe |
| reg_ring_i | input | RING_W | Ring the command applies to |
| reg_op_i | input | 2 | 0 base, 1 config, 2 doorbell, 3 clear |
| reg_data_i | input | ADDR_W | Command operand |
| mem_rd_valid_o | output | 1 | Translated read issued |
| mem_rd_addr_o | output | ADDR_W | Head slot address |
| rd_err_o | output | 1 | Read refused (ring empty) |
| mem_wr_valid_o | output | 1 | Translated write issued |
| mem_wr_addr_o | output | ADDR_W | Tail slot address |
| wr_err_o | output | 1 | Write refused (ring full) |
| empty_o | output | NUM_RINGS | Per-ring empty flag |
| full_o | output | NUM_RINGS | Per-ring full flag |
| occ_o | output | NUM_RINGS*OCC_W | Per-ring occupancy |

## Verification
The bench fills a two-slot ring past full and then drains it past empty. A design that miscounts the wrap would reissue a stale slot, and one that ignores the full or empty state would move a pointer on a refused access. A same-cycle read, write and doorbell on one ring catches a design that serves only one of them or drops the doorbell. Doorbells of 200, 100 and 53 test the count limit and the wrap of the occupancy to exactly zero; a wrong clamp or a saturating counter leaves a non-zero occupancy and a misplaced tail. A mode switch and a clear check that queue mode blocks doorbells and that a clear really rewinds both pointers.

// File: rtl/ring_proxy_pkg.sv
package ring_proxy_pkg;
  typedef enum logic [1:0] {
    OP_BASE     = 2'd0,
    OP_CFG      = 2'd1,
    OP_DOORBELL = 2'd2,
    OP_CLEAR    = 2'd3
  } reg_op_e;

  typedef enum logic {
    MODE_RING  = 1'b0,
    MODE_QUEUE = 1'b1
  } ring_mode_e;
endpackage

// File: rtl/ring_proxy_slot.sv
module ring_proxy_slot
  import ring_proxy_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OCC_W   = 8,
  parameter int MAX_LOG = 4,
  parameter int LOG_W   = 3,
  parameter int DB_W    = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_we_i,
  input  logic               cfg_we_i,
  input  logic               db_we_i,
  input  logic               clr_we_i,
  input  logic [ADDR_W-1:0]  reg_data_i,
  input  logic [DB_W-1:0]    db_cnt_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [MAX_LOG-1:0] head_o,
  output logic [MAX_LOG-1:0] tail_o,
  output logic [OCC_W-1:0]   occ_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [LOG_W-1:0]   log2_q, log2_new;
  ring_mode_e         mode_q;
  logic [MAX_LOG-1:0] head_q, tail_q, mask;
  logic [OCC_W-1:0]   occ_q, occ_nxt;
  logic [OCC_W:0]     size;
  logic               db_eff;
  logic [31:0]        mask_w;

  assign mask_w   = (32'd1 << log2_q) - 32'd1;
  assign mask     = mask_w[MAX_LOG-1:0];
  assign size     = (OCC_W+1)'(1) << log2_q;
  assign empty_o  = (occ_q == '0);
  assign full_o   = ({1'b0, occ_q} >= size);
  assign db_eff   = db_we_i && (mode_q == MODE_RING);
  assign rd_ok_o  = rd_req_i && !empty_o;
  assign wr_ok_o  = wr_req_i && !full_o;
  assign log2_new = (reg_data_i[LOG_W-1:0] > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG)
                                                              : reg_data_i[LOG_W-1:0];
  assign occ_nxt  = occ_q + OCC_W'(wr_ok_o) - OCC_W'(rd_ok_o)
                  + (db_eff ? OCC_W'(db_cnt_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      log2_q <= LOG_W'(MAX_LOG);
      mode_q <= MODE_RING;
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (base_we_i) base_q <= reg_data_i;
      if (cfg_we_i) begin
        log2_q <= log2_new;
        mode_q <= ring_mode_e'(reg_data_i[7]);
      end
      if (clr_we_i) begin
        head_q <= '0;
        tail_q <= '0;
        occ_q  <= '0;
      end else begin
        head_q <= (head_q + MAX_LOG'(rd_ok_o)) & mask;
        tail_q <= (tail_q + MAX_LOG'(wr_ok_o) + (db_eff ? MAX_LOG'(db_cnt_i) : '0)) & mask;
        occ_q  <= occ_nxt;
      end
    end
  end

  assign base_o = base_q;
  assign head_o = head_q;
  assign tail_o = tail_q;
  assign occ_o  = occ_q;

  // R4
  rd_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && empty_o && !clr_we_i) |=> $stable(head_q));
  // R4
  wr_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && full_o && !clr_we_i && !db_eff) |=> $stable(tail_q));
  // R9
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (occ_q == '0 && head_q == '0 && tail_q == '0));
  // R10
  queue_db_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_we_i && mode_q == MODE_QUEUE && !rd_req_i && !wr_req_i && !clr_we_i) |=> $stable(occ_q));
  // R5
  both_net_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok_o && wr_ok_o && !db_eff && !clr_we_i) |=> $stable(occ_q));
endmodule

// File: rtl/ring_proxy_xlat.sv
module ring_proxy_xlat #(
  parameter int ADDR_W     = 32,
  parameter int MAX_LOG    = 4,
  parameter int ELEM_SHIFT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               ok_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [MAX_LOG-1:0] ptr_i,
  output logic               mem_valid_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      mem_addr_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      mem_valid_o <= req_i && ok_i;
      err_o       <= req_i && !ok_i;
      if (req_i && ok_i) mem_addr_o <= base_i + (ADDR_W'(ptr_i) << ELEM_SHIFT);
    end
  end
endmodule

// File: rtl/ring_proxy.sv
module ring_proxy
  import ring_proxy_pkg::*;
#(
  parameter int NUM_RINGS  = 4,
  parameter int ADDR_W     = 32,
  parameter int OCC_W      = 8,
  parameter int MAX_LOG    = 4,
  parameter int ELEM_BYTES = 8,
  parameter int DB_MAX     = 100,
  localparam int RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_valid_i,
  input  logic [RING_W-1:0]          rd_ring_i,
  input  logic                       wr_valid_i,
  input  logic [RING_W-1:0]          wr_ring_i,
  input  logic                       reg_valid_i,
  input  logic [RING_W-1:0]          reg_ring_i,
  input  logic [1:0]                 reg_op_i,
  input  logic [ADDR_W-1:0]          reg_data_i,
  output logic                       mem_rd_valid_o,
  output logic [ADDR_W-1:0]          mem_rd_addr_o,
  output logic                       rd_err_o,
  output logic                       mem_wr_valid_o,
  output logic [ADDR_W-1:0]          mem_wr_addr_o,
  output logic                       wr_err_o,
  output logic [NUM_RINGS-1:0]       empty_o,
  output logic [NUM_RINGS-1:0]       full_o,
  output logic [NUM_RINGS*OCC_W-1:0] occ_o
);
  localparam int LOG_W      = $clog2(MAX_LOG + 1);
  localparam int DB_W       = $clog2(DB_MAX + 1);
  localparam int ELEM_SHIFT = $clog2(ELEM_BYTES);

  reg_op_e            op;
  logic [DB_W-1:0]    db_cnt;
  logic [ADDR_W-1:0]  base_a [NUM_RINGS];
  logic [MAX_LOG-1:0] head_a [NUM_RINGS];
  logic [MAX_LOG-1:0] tail_a [NUM_RINGS];
  logic [NUM_RINGS-1:0] rd_ok_a, wr_ok_a;

  assign op     = reg_op_e'(reg_op_i);
  assign db_cnt = (reg_data_i > ADDR_W'(DB_MAX)) ? DB_W'(DB_MAX) : reg_data_i[DB_W-1:0];

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    logic sel;
    assign sel = reg_valid_i && (reg_ring_i == RING_W'(r));
    ring_proxy_slot #(
      .ADDR_W(ADDR_W), .OCC_W(OCC_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W), .DB_W(DB_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .base_we_i  (sel && op == OP_BASE),
      .cfg_we_i   (sel && op == OP_CFG),
      .db_we_i    (sel && op == OP_DOORBELL),
      .clr_we_i   (sel && op == OP_CLEAR),
      .reg_data_i (reg_data_i),
      .db_cnt_i   (db_cnt),
      .rd_req_i   (rd_valid_i && rd_ring_i == RING_W'(r)),
      .wr_req_i   (wr_valid_i && wr_ring_i == RING_W'(r)),
      .base_o     (base_a[r]),
      .head_o     (head_a[r]),
      .tail_o     (tail_a[r]),
      .occ_o      (occ_o[r*OCC_W +: OCC_W]),
      .empty_o    (empty_o[r]),
      .full_o     (full_o[r]),
      .rd_ok_o    (rd_ok_a[r]),
      .wr_ok_o    (wr_ok_a[r])
    );
  end

  ring_proxy_xlat #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .ELEM_SHIFT(ELEM_SHIFT)) u_rd_xlat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (rd_valid_i),
    .ok_i        (rd_ok_a[rd_ring_i]),
    .base_i      (base_a[rd_ring_i]),
    .ptr_i       (head_a[rd_ring_i]),
    .mem_valid_o (mem_rd_valid_o),
    .mem_addr_o  (mem_rd_addr_o),
    .err_o       (rd_err_o)
  );

  ring_proxy_xlat #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .ELEM_SHIFT(ELEM_SHIFT)) u_wr_xlat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (wr_valid_i),
    .ok_i        (wr_ok_a[wr_ring_i]),
    .base_i      (base_a[wr_ring_i]),
    .ptr_i       (tail_a[wr_ring_i]),
    .mem_valid_o (mem_wr_valid_o),
    .mem_addr_o  (mem_wr_addr_o),
    .err_o       (wr_err_o)
  );

  // R1
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> (mem_rd_valid_o ^ rd_err_o));
  // R2
  wr_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (mem_wr_valid_o ^ wr_err_o));
  // R4
  rd_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_valid_o && rd_err_o));
endmodule

// File: tb/ring_proxy_tb_top.sv
module ring_proxy_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_valid_i = 1'b0, wr_valid_i = 1'b0, reg_valid_i = 1'b0;
  logic [1:0]  rd_ring_i = '0, wr_ring_i = '0, reg_ring_i = '0, reg_op_i = '0;
  logic [31:0] reg_data_i = '0;
  logic        mem_rd_valid_o, rd_err_o, mem_wr_valid_o, wr_err_o;
  logic [31:0] mem_rd_addr_o, mem_wr_addr_o;
  logic [3:0]  empty_o, full_o;
  logic [31:0] occ_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ring_proxy dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_valid_i(rd_valid_i), .rd_ring_i(rd_ring_i),
    .wr_valid_i(wr_valid_i), .wr_ring_i(wr_ring_i),
    .reg_valid_i(reg_valid_i), .reg_ring_i(reg_ring_i),
    .reg_op_i(reg_op_i), .reg_data_i(reg_data_i),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o), .rd_err_o(rd_err_o),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_addr_o(mem_wr_addr_o), .wr_err_o(wr_err_o),
    .empty_o(empty_o), .full_o(full_o), .occ_o(occ_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] occ_of(input int r);
    return occ_o[r*8 +: 8];
  endfunction

  // one cycle of stimulus; returns at the next falling edge with results visible
  task automatic step(input logic rv, input logic [1:0] rr, input logic wv, input logic [1:0] wr,
                      input logic gv, input logic [1:0] gr, input logic [1:0] gop,
                      input logic [31:0] gd);
    rd_valid_i = rv; rd_ring_i = rr; wr_valid_i = wv; wr_ring_i = wr;
    reg_valid_i = gv; reg_ring_i = gr; reg_op_i = gop; reg_data_i = gd;
    @(negedge clk_i);
    rd_valid_i = 0; wr_valid_i = 0; reg_valid_i = 0;
  endtask

  task automatic cmd(input logic [1:0] r, input logic [1:0] op, input logic [31:0] d);
    step(0, 0, 0, 0, 1, r, op, d);
  endtask
  task automatic rd(input logic [1:0] r);
    step(1, r, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [1:0] r);
    step(0, 0, 1, r, 0, 0, 0, 0);
  endtask

  task automatic expect_rd(input string tag, input logic [31:0] a);
    chk({tag, " rd valid"}, mem_rd_valid_o, 1);
    chk({tag, " rd addr"}, mem_rd_addr_o, a);
  endtask
  task automatic expect_wr(input string tag, input logic [31:0] a);
    chk({tag, " wr valid"}, mem_wr_valid_o, 1);
    chk({tag, " wr addr"}, mem_wr_addr_o, a);
  endtask

  task automatic t_reset_state;
    chk("R12 empty after reset", empty_o, 4'hF);
    chk("R12 full after reset", full_o, 4'h0);
    chk("R12 occ after reset", occ_o, 0);
    chk("R12 no mem valid", {mem_rd_valid_o, mem_wr_valid_o, rd_err_o, wr_err_o}, 0);
    rd(0);
    chk("R4 read on empty ring0 err", rd_err_o, 1);
    chk("R4 read on empty no valid", mem_rd_valid_o, 0);
  endtask

  task automatic t_translate;
    cmd(1, 0, 32'h1000);
    cmd(1, 1, 32'd2);
    wr(1); expect_wr("R2 first write", 32'h1000);
    wr(1); expect_wr("R3 second write next slot", 32'h1008);
    chk("R11 occ ring1=2", occ_of(1), 2);
    rd(1); expect_rd("R1 first read head", 32'h1000);
    rd(1); expect_rd("R1 second read", 32'h1008);
    chk("R11 empty ring1", empty_o[1], 1);
    rd(1);
    chk("R4 read empty ring1 err", rd_err_o, 1);
    wr(1); expect_wr("R4 head/tail unmoved after refusal", 32'h1010);
  endtask

  task automatic t_wrap_full;
    cmd(2, 0, 32'h2000);
    cmd(2, 1, 32'd1);
    wr(2); expect_wr("R2 ring2 slot0", 32'h2000);
    wr(2); expect_wr("R2 ring2 slot1", 32'h2008);
    chk("R11 ring2 full", full_o[2], 1);
    wr(2);
    chk("R4 write on full err", wr_err_o, 1);
    chk("R4 write on full no valid", mem_wr_valid_o, 0);
    chk("R4 occ kept", occ_of(2), 2);
    rd(2); expect_rd("R1 ring2 head0", 32'h2000);
    wr(2); expect_wr("R3 tail wraps to slot0", 32'h2000);
    rd(2); expect_rd("R3 head slot1", 32'h2008);
    rd(2); expect_rd("R3 head wraps to slot0", 32'h2000);
    chk("R11 ring2 empty", empty_o[2], 1);
  endtask

  task automatic t_concurrent;
    cmd(3, 0, 32'h3000);
    cmd(3, 1, 32'd3);
    wr(3); expect_wr("R2 ring3 first", 32'h3000);
    step(1, 3, 1, 3, 0, 0, 0, 0);
    expect_rd("R5 same-cycle read", 32'h3000);
    expect_wr("R5 same-cycle write", 32'h3008);
    chk("R5 occ net unchanged", occ_of(3), 1);
    step(1, 3, 1, 3, 1, 3, 2, 32'd5);
    expect_rd("R6 read with doorbell", 32'h3008);
    expect_wr("R6 write with doorbell", 32'h3010);
    chk("R6 doorbell adds on top", occ_of(3), 6);
    wr(3); expect_wr("R6 tail advanced by doorbell", 32'h3000);
    chk("R6 occ after write", occ_of(3), 7);
  endtask

  task automatic t_clear;
    cmd(3, 3, 32'd0);
    chk("R9 clear occ", occ_of(3), 0);
    chk("R9 clear empty", empty_o[3], 1);
    wr(3); expect_wr("R9 tail rewound", 32'h3000);
    rd(3); expect_rd("R9 head rewound", 32'h3000);
  endtask

  task automatic t_doorbell;
    cmd(0, 2, 32'd3);
    chk("R6 doorbell 3", occ_of(0), 3);
    cmd(0, 2, 32'd200);
    chk("R7 doorbell clamped to 100", occ_of(0), 103);
    chk("R11 ring0 full", full_o[0], 1);
    wr(0);
    chk("R4 full ring0 refuses write", wr_err_o, 1);
    cmd(0, 2, 32'd100);
    chk("R8 occ 203", occ_of(0), 203);
    cmd(0, 2, 32'd53);
    chk("R8 occ wraps to zero", occ_of(0), 0);
    chk("R8 empty after wrap", empty_o[0], 1);
    wr(0); expect_wr("R6 tail moved by doorbells mod size", 32'h0);
    chk("R11 occ ring0 =1", occ_of(0), 1);
  endtask

  task automatic t_mode;
    cmd(0, 1, 32'h84);
    cmd(0, 2, 32'd5);
    chk("R10 queue mode ignores doorbell", occ_of(0), 1);
    wr(0); expect_wr("R10 window works in queue mode", 32'h8);
    cmd(0, 1, 32'h04);
    chk("R10 mode switch keeps occ", occ_of(0), 2);
    cmd(0, 2, 32'd5);
    chk("R10 ring mode restored", occ_of(0), 7);
    cmd(0, 1, 32'h07);
    cmd(0, 3, 32'd0);
    wr(0); expect_wr("R10 size limited to max", 32'h0);
    chk("R11 not full at 1 of 16", full_o[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_translate();
    t_wrap_full();
    t_concurrent();
    t_clear();
    t_doorbell();
    t_mode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule